// File: doc/BRIEF.md
# Protected-Write Clock Prescaler

This block derives the system clock from a master clock by dividing it by a power of two. A single 8-bit control register, reached through a plain write strobe and a read-back value, holds a change-enable flag and a 4-bit division code. The division code cannot be altered by a single stray write. Software must first write an unlock word, and then write the new code within a short window of master-clock cycles. Once that window has passed, the block ignores further code writes.

The divided clock comes from taps of a free-running counter. The division of one passes the master clock through a gate that is enabled on the falling edge. When the code changes, the output moves to the new tap only at an edge where both the old and the new tap are low. As a result the output never shows a pulse or gap shorter than half a period of the faster of the two settings. A strap input picks the reset division, so that a fast source can start divided by eight.

Top module: `protClkDiv`

## Requirements
- R1: The read-back value is {enable flag in bit 7, zeros in bits 6..4, division code in bits 3..0}. Bits 6..4 read as zero whatever was written to them.
- R2: The enable flag is set only by a write of exactly 8'h80 while the flag is clear. A write of any other value never sets the flag.
- R3: Once set, the flag stays high for exactly four master cycles. A code write sampled on the first, second, third or fourth rising edge after the arming edge is accepted. A code write on the fifth edge is ignored.
- R4: Writing 8'h80 again while the flag is set neither clears the flag nor restarts its four-cycle timeout.
- R5: The division code changes only through a write with bit 7 at 0 while the flag is set, and that write clears the flag. A write with bit 7 at 0 while the flag is clear is ignored. A write with bit 7 at 1 while the flag is set is ignored and leaves the flag set.
- R6: Reset clears the flag and loads code 0 when the strap is low, or code 3 (divide by 8) when it is high. After reset, any code may be written whatever the strap level.
- R7: For code c from 0 to 8, the divided clock has period 2^c master cycles. For c of 1 or more, each high phase and each low phase lasts 2^(c-1) master cycles. For c = 0, the output follows the master clock.
- R8: Codes 9 to 15 read back as written and divide by 256.
- R9: The output moves to a new code only at a master edge after which both the old and the new tap are low. No high or low phase during a switch is shorter than half the period of the faster setting. The new rate is in force within 512 master cycles of acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| strapDiv8 | input | 1 | Selects divide-by-8 as the reset setting |
| wrEn | input | 1 | Register write strobe, sampled on the rising edge |
| wrData | input | 8 | Register write data |
| divClk | output | 1 | Divided system clock |
| rdData | output | 8 | Register read-back value |
| chgEnable | output | 1 | Current state of the change-enable flag |

## Verification
The hardest situations to reach are the edges of the unlock window. One is a code write landing on the fifth cycle instead of the fourth. The other is a second unlock word arriving mid-window, which must not stretch the window. The bench places every write on a chosen master edge, counted from the arming write, to hit both cases. A switch can meet the counter at any phase. The bench therefore waits a varying number of idle cycles before each code change, so that switches between slow and fast settings, in both directions, start at different counter alignments. A monitor samples the output every half master cycle and checks the length of every phase against the faster of the two settings.

// File: rtl/protDivPkg.sv
package protDivPkg;
  localparam int REG_W = 8;
  localparam int SEL_W = 4;
  localparam logic [REG_W-1:0] ARM_WORD = 8'h80;

  typedef struct packed {
    logic             load;
    logic [SEL_W-1:0] code;
  } selStrobe_t;
endpackage

// File: rtl/protDivCtrl.sv
module protDivCtrl
  import protDivPkg::*;
#(
  parameter int WINDOW          = 4,
  parameter int RESET_SLOW_CODE = 3
) (
  input  logic             clkIn,
  input  logic             rstN,
  input  logic             strapDiv8,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic             chgEnable,
  output logic [SEL_W-1:0] selCode,
  output selStrobe_t       strobe
);
  localparam int TMR_W   = (WINDOW > 2) ? $clog2(WINDOW) : 1;
  localparam int EN_BIT  = REG_W - 1;
  localparam int OPEN_W  = TMR_W + 2;

  logic             enQ;
  logic [TMR_W-1:0] tmrQ;
  logic [SEL_W-1:0] selQ;
  logic             armHit;
  logic             selHit;

  assign armHit = wrEn && (wrData == ARM_WORD);
  assign selHit = wrEn && !wrData[EN_BIT] && enQ;

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      enQ  <= 1'b0;
      tmrQ <= '0;
      selQ <= strapDiv8 ? SEL_W'(RESET_SLOW_CODE) : '0;
    end else if (enQ) begin
      if (selHit) begin
        selQ <= wrData[SEL_W-1:0];
        enQ  <= 1'b0;
      end else if (tmrQ == '0) begin
        enQ <= 1'b0;
      end else begin
        tmrQ <= tmrQ - 1'b1;
      end
    end else if (armHit) begin
      enQ  <= 1'b1;
      tmrQ <= TMR_W'(WINDOW - 1);
    end
  end

  assign chgEnable   = enQ;
  assign selCode     = selQ;
  assign strobe.load = selHit;
  assign strobe.code = wrData[SEL_W-1:0];

  // window length checker
  logic [OPEN_W-1:0] openCnt;
  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) openCnt <= '0;
    else       openCnt <= enQ ? openCnt + 1'b1 : '0;
  end

  // R3
  window_len_chk: assert property (@(posedge clkIn) disable iff (!rstN)
    openCnt <= OPEN_W'(WINDOW));

  // R2
  arm_pattern_chk: assert property (@(posedge clkIn) disable iff (!rstN)
    $rose(enQ) |-> $past(wrEn && (wrData == ARM_WORD)));

  // R4
  rearm_no_extend_chk: assert property (@(posedge clkIn) disable iff (!rstN)
    (enQ && tmrQ != '0 && armHit) |=> (enQ && tmrQ == $past(tmrQ) - 1'b1));

  // R5
  sel_guard_chk: assert property (@(posedge clkIn) disable iff (!rstN)
    !(wrEn && !wrData[EN_BIT] && enQ) |=> $stable(selQ));
endmodule

// File: rtl/protDivPath.sv
module protDivPath
  import protDivPkg::*;
#(
  parameter int MAX_CODE        = 8,
  parameter int RESET_SLOW_CODE = 3
) (
  input  logic       clkIn,
  input  logic       rstN,
  input  logic       strapDiv8,
  input  selStrobe_t strobe,
  output logic       divClk
);
  localparam int CNT_W = MAX_CODE;
  localparam int K_W   = $clog2(MAX_CODE + 1);

  function automatic logic [K_W-1:0] clampCode(input logic [SEL_W-1:0] c);
    if (int'(c) > MAX_CODE) return K_W'(MAX_CODE);
    return K_W'(c);
  endfunction

  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  nextCnt;
  logic [K_W-1:0]    activeK;
  logic [K_W-1:0]    targetK;
  logic [K_W-1:0]    resetK;
  logic              tapQ;
  logic              oneModeQ;
  logic              bypassQ;
  logic [MAX_CODE:0] tapVec;
  logic              oldLow;
  logic              newLow;
  logic              switchNow;

  assign nextCnt = cntQ + 1'b1;
  assign resetK  = strapDiv8 ? K_W'(RESET_SLOW_CODE) : '0;

  // tap k carries the counter bit that divides by 2^k; tap 0 is the gated path
  assign tapVec[0] = 1'b0;
  for (genvar k = 1; k <= MAX_CODE; k++) begin : g_tap
    assign tapVec[k] = nextCnt[k-1];
  end

  assign oldLow    = !tapVec[activeK];
  assign newLow    = !tapVec[targetK];
  assign switchNow = (targetK != activeK) && oldLow && newLow;

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      cntQ     <= '0;
      activeK  <= resetK;
      targetK  <= resetK;
      tapQ     <= 1'b0;
      oneModeQ <= (resetK == '0);
    end else begin
      cntQ <= nextCnt;
      if (strobe.load) targetK <= clampCode(strobe.code);
      if (switchNow) begin
        activeK  <= targetK;
        tapQ     <= tapVec[targetK];
        oneModeQ <= (targetK == '0);
      end else begin
        tapQ <= tapVec[activeK];
      end
    end
  end

  // gate for the undivided path changes only while the master clock is low
  always_ff @(negedge clkIn or negedge rstN) begin
    if (!rstN) bypassQ <= (resetK == '0);
    else       bypassQ <= oneModeQ;
  end

  assign divClk = tapQ | (clkIn & bypassQ);

  // R9
  switch_low_chk: assert property (@(posedge clkIn) disable iff (!rstN)
    !$stable(activeK) |-> !tapQ);

  // R8
  code_range_chk: assert property (@(posedge clkIn) disable iff (!rstN)
    (activeK <= K_W'(MAX_CODE)) && (targetK <= K_W'(MAX_CODE)));

  // R7
  div2_toggle_chk: assert property (@(posedge clkIn) disable iff (!rstN)
    (activeK == K_W'(1) && $past(activeK) == K_W'(1) && $past(activeK, 2) == K_W'(1))
      |-> (tapQ != $past(tapQ)));
endmodule

// File: rtl/protClkDiv.sv
module protClkDiv
  import protDivPkg::*;
#(
  parameter int WINDOW          = 4,
  parameter int MAX_CODE        = 8,
  parameter int RESET_SLOW_CODE = 3
) (
  input  logic       clkIn,
  input  logic       rstN,
  input  logic       strapDiv8,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic       divClk,
  output logic [7:0] rdData,
  output logic       chgEnable
);
  localparam int PAD_W = REG_W - SEL_W - 1;

  logic [SEL_W-1:0] selCode;
  selStrobe_t       strobe;

  protDivCtrl #(
    .WINDOW(WINDOW),
    .RESET_SLOW_CODE(RESET_SLOW_CODE)
  ) u_ctrl (
    .clkIn(clkIn),
    .rstN(rstN),
    .strapDiv8(strapDiv8),
    .wrEn(wrEn),
    .wrData(wrData),
    .chgEnable(chgEnable),
    .selCode(selCode),
    .strobe(strobe)
  );

  protDivPath #(
    .MAX_CODE(MAX_CODE),
    .RESET_SLOW_CODE(RESET_SLOW_CODE)
  ) u_path (
    .clkIn(clkIn),
    .rstN(rstN),
    .strapDiv8(strapDiv8),
    .strobe(strobe),
    .divClk(divClk)
  );

  // R1
  assign rdData = {chgEnable, {PAD_W{1'b0}}, selCode};
endmodule

// File: tb/protClkDiv_bench.sv
`timescale 1ns/1ps
module protClkDiv_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       strapDiv8 = 1'b1;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       divClk;
  logic [7:0] rdData;
  logic       chgEnable;

  integer compared = 0;
  integer mismatched = 0;
  bit     done = 1'b0;

  always #10 clk = ~clk;

  protClkDiv u_protClkDiv (
    .clkIn(clk), .rstN(rstN), .strapDiv8(strapDiv8), .wrEn(wrEn),
    .wrData(wrData), .divClk(divClk), .rdData(rdData), .chgEnable(chgEnable)
  );

  task automatic chk(input string tag, input integer act, input integer exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic integer factorOf(input integer code);
    return (code > 8) ? 256 : (1 << code);
  endfunction

  // behavioural model of the register, advanced on each rising edge
  bit     mEn;
  integer mLeft;
  integer mSel;
  always @(posedge clk) begin
    if (!rstN) begin
      mEn = 0; mLeft = 0; mSel = strapDiv8 ? 3 : 0;
    end else if (mEn) begin
      if (wrEn && !wrData[7]) begin
        mSel = wrData[3:0]; mEn = 0;
      end else begin
        mLeft = mLeft - 1;
        if (mLeft == 0) mEn = 0;
      end
    end else if (wrEn && wrData == 8'h80) begin
      mEn = 1; mLeft = 4;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      chk("R1 R5 readback", rdData, {mEn, 3'b000, mSel[3:0]});
      chk("R3 enable flag", chgEnable, mEn);
    end
  end

  // phase monitor, lengths in half master cycles
  logic   sPrev;
  integer runLen = 0;
  bit     skipFirst = 1'b1;
  integer minAllowed = 8;
  integer lastHigh = 0;
  integer lastLow = 0;
  always begin
    @(clk);
    #5;
    if (!rstN) begin
      runLen = 1; skipFirst = 1'b1; sPrev = divClk;
    end else if (divClk === sPrev) begin
      runLen++;
    end else begin
      if (!skipFirst) begin
        compared++;
        if (runLen < minAllowed) begin
          mismatched++;
          $display("FAIL R9 phase length actual=%0d expected>=%0d", runLen, minAllowed);
        end
        if (sPrev) lastHigh = runLen; else lastLow = runLen;
      end
      skipFirst = 1'b0;
      runLen = 1;
      sPrev = divClk;
    end
  end

  task automatic wr(input logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = 8'h00;
  endtask

  task automatic idle(input integer n);
    repeat (n) @(negedge clk);
  endtask

  integer curF = 8;

  task automatic settleAndMeasure(input integer fNew, input string tag);
    idle(1200);
    minAllowed = fNew;
    chk({tag, " high phase"}, lastHigh, fNew);
    chk({tag, " low phase"}, lastLow, fNew);
    curF = fNew;
  endtask

  task automatic setCode(input integer code, input integer preIdle);
    integer fNew;
    fNew = factorOf(code);
    idle(preIdle);
    minAllowed = (curF < fNew) ? curF : fNew;
    wr(8'h80);
    idle(1);
    wr(code[7:0]);
    chk("R5 code accepted", rdData, code);
    settleAndMeasure(fNew, (code > 8) ? "R8 reserved" : "R7 period");
  endtask

  task automatic doReset(input logic strap);
    @(negedge clk);
    rstN = 1'b0; strapDiv8 = strap;
    idle(4);
    rstN = 1'b1;
    curF = strap ? 8 : 1;
    minAllowed = curF;
  endtask

  initial begin
    idle(4);
    rstN = 1'b1;
    // reset state with strap high
    chk("R6 reset code strap high", rdData, 8'h03);
    chk("R6 reset flag", chgEnable, 0);
    settleAndMeasure(8, "R6 R7 reset div8");

    // wrong arm pattern
    wr(8'h81);
    chk("R2 wrong pattern", chgEnable, 0);
    wr(8'h00);
    chk("R5 write while locked", rdData, 8'h03);

    // fifth-cycle write ignored
    wr(8'h80);
    chk("R2 arm sets flag", chgEnable, 1);
    idle(4);
    wr(8'h01);
    chk("R3 late write flag", chgEnable, 0);
    chk("R3 late write code", rdData, 8'h03);

    // fourth-cycle write accepted
    minAllowed = 4;
    wr(8'h80);
    idle(3);
    wr(8'h02);
    chk("R3 fourth-edge write", rdData, 8'h02);
    settleAndMeasure(4, "R7 div4");

    // repeated arm does not extend
    wr(8'h80);
    wr(8'h80);
    chk("R4 rearm keeps flag", chgEnable, 1);
    idle(1);
    wr(8'h80);
    chk("R4 rearm flag third", chgEnable, 1);
    idle(1);
    chk("R4 timeout not restarted", chgEnable, 0);
    wr(8'h05);
    chk("R4 write after timeout", rdData, 8'h02);

    // bit 7 set while open, then padding bits
    wr(8'h80);
    wr(8'h83);
    chk("R5 bit7 write keeps flag", chgEnable, 1);
    chk("R5 bit7 write keeps code", rdData[3:0], 2);
    minAllowed = 1;
    wr(8'h70);
    chk("R1 padding reads zero", rdData, 8'h00);
    settleAndMeasure(1, "R7 div1");

    // switches at various counter alignments
    setCode(1, 3);
    setCode(8, 7);
    setCode(12, 13);
    setCode(0, 29);
    setCode(5, 41);
    setCode(15, 2);
    setCode(2, 57);
    setCode(4, 11);

    // strap low reset, then any code allowed
    doReset(1'b0);
    chk("R6 reset code strap low", rdData, 8'h00);
    settleAndMeasure(1, "R6 R7 reset div1");
    setCode(3, 5);
    doReset(1'b1);
    chk("R6 reset code strap high again", rdData, 8'h03);
    setCode(0, 9);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule